// File: doc/BRIEF.md
# BCD Calendar Clock with Frozen Readout

This block keeps the time of day and the calendar as packed BCD fields: seconds, minutes, hours, day of week, date, month, year and century. A sub-second tick input drives it, and a parameter gives the number of these ticks in one second. A 16-byte register window gives the host access to the fields. The host writes each field directly and reads a separate external copy of the count.

The internal count always advances while the oscillator-stop bit is clear. The external copy normally follows the internal count once per second. Setting the read-hold bit freezes the external copy at the count current at that moment, so a read of several bytes stays consistent. The internal count keeps running during the hold. After the hold is released, the external copy stays frozen until the hold bit has been clear for a guard time of sub-second ticks. On the tick that ends the guard it picks up the running count, and from then on it updates every second.

Top module: `rtc_frozen_clock`

## Requirements
- R1: After reset the window reads: offset 15 (year) 00, 14 (month) 01, 13 (date) 01, 12 (day of week) 01, 11 (hour) 00, 10 (minutes) 00, 9 (seconds) 80h, 8 (control) 00h, and offsets 0 to 7 read 00h.
- R2: The seconds field advances by one on every TICKS_PER_SEC-th sub-second tick while the clock runs. Seconds roll 59 to 00 into minutes, minutes roll 59 to 00 into hours, and hours roll 23 to 00 into the day fields. BCD digits carry at 9.
- R3: Bit 7 of the seconds byte (offset 9) stops the clock when it is 1. While it is set no field changes on ticks. Writing 0 restarts counting.
- R4: At midnight the day of week (offset 12) advances, wrapping from 07 to 01.
- R5: At midnight the date advances until the month's last day, then becomes 01 and the month advances. Months 04, 06, 09 and 11 have 30 days, and February has 29 days when the year is divisible by 4 and 28 otherwise.
- R6: Month 12 rolls to 01 into the year. Year 99 rolls to 00 and increments the century in bits 5:0 of the control byte (offset 8). Century 39 rolls to 00.
- R7: Writing 1 to bit 6 of the control byte freezes every host-visible time field at the count current at that moment. The internal count keeps advancing during the hold.
- R8: After bit 6 is written 0, the visible fields stay frozen until GUARD_TICKS sub-second ticks have passed. On the GUARD_TICKS-th tick they take the running count, and after that they update with every second.
- R9: Bits with no function read as 0. The write masks are: seconds 7Fh plus the stop bit, minutes 7Fh, hours 3Fh, day 07h, date 3Fh, month 1Fh, year FFh, century 3Fh. Control bit 7 reads 0, and offsets 0 to 7 ignore writes.
- R10: A write to a time byte loads both the internal and the visible copy at once. A write to the seconds byte also restarts the sub-second count, so the next second follows a full TICKS_PER_SEC ticks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_sub | input | 1 | Sub-second tick, one clock wide |
| bus_addr | input | 4 | Register offset within the window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data from the visible copy |

## Verification
The bench goes after the carry chain at its edges: midnight on the last day of the year, the leap and non-leap February ends, 30-day months, and a century wrap. A design with a wrong month table or a wrong leap test lands on an impossible date or skips the 29th. The hold sequence checks that the readout freezes while the count runs underneath, that it stays stale through the guard ticks, and that it jumps to the live count on the exact tick the guard ends. A design with a missing guard would update at once, and one that re-syncs only on whole seconds would lag. A seconds write in the middle of a second catches a prescaler that is not restarted, because that design advances early.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   typedef struct packed {
      logic [7:0] century;
      logic [7:0] year;
      logic [7:0] month;
      logic [7:0] date;
      logic [7:0] day;
      logic [7:0] hour;
      logic [7:0] min;
      logic [7:0] sec;
   } rtc_time_t;

   localparam logic [3:0] OFF_YEAR  = 4'hF;
   localparam logic [3:0] OFF_MONTH = 4'hE;
   localparam logic [3:0] OFF_DATE  = 4'hD;
   localparam logic [3:0] OFF_DAY   = 4'hC;
   localparam logic [3:0] OFF_HOUR  = 4'hB;
   localparam logic [3:0] OFF_MIN   = 4'hA;
   localparam logic [3:0] OFF_SEC   = 4'h9;
   localparam logic [3:0] OFF_CTRL  = 4'h8;

   localparam logic [7:0] MSK_SEC   = 8'h7F;
   localparam logic [7:0] MSK_MIN   = 8'h7F;
   localparam logic [7:0] MSK_HOUR  = 8'h3F;
   localparam logic [7:0] MSK_DAY   = 8'h07;
   localparam logic [7:0] MSK_DATE  = 8'h3F;
   localparam logic [7:0] MSK_MONTH = 8'h1F;
   localparam logic [7:0] MSK_YEAR  = 8'hFF;
   localparam logic [7:0] MSK_CENT  = 8'h3F;

   localparam int STOP_BIT = 7;
   localparam int HOLD_BIT = 6;

   localparam rtc_time_t TIME_AT_RESET = '{century: 8'h00, year: 8'h00,
                                           month: 8'h01, date: 8'h01,
                                           day: 8'h01, hour: 8'h00,
                                           min: 8'h00, sec: 8'h00};

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // Last date of a month; a year is leap when (10*tens + ones) mod 4 == 0,
   // which equals (2*tens + ones) mod 4 == 0.
   function automatic logic [7:0] month_last(input logic [7:0] month,
                                             input logic [7:0] year);
      logic [4:0] s;
      logic       leap;
      s    = {year[7:4], 1'b0} + {1'b0, year[3:0]};
      leap = (s[1:0] == 2'b00);
      case (month)
         8'h02:                      return leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
   import rtc_pkg::*;
#(
   parameter logic [7:0] WRAP_TO = 8'h00
) (
   input  logic [7:0] cur,
   input  logic       carry_in,
   input  logic       at_top,
   output logic [7:0] nxt
);

   always_comb begin
      if (!carry_in)   nxt = cur;
      else if (at_top) nxt = WRAP_TO;
      else             nxt = bcd_inc(cur);
   end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_pkg::*;
(
   input  rtc_time_t cur,
   output rtc_time_t nxt
);

   logic top_sec, top_min, top_hour, top_day, top_date, top_mon, top_year, top_cent;
   logic c_min, c_hour, c_day, c_mon, c_year, c_cent;

   always_comb begin
      top_sec  = (cur.sec   >= 8'h59);
      top_min  = (cur.min   >= 8'h59);
      top_hour = (cur.hour  >= 8'h23);
      top_day  = (cur.day   >= 8'h07);
      top_date = (cur.date  >= month_last(cur.month, cur.year));
      top_mon  = (cur.month >= 8'h12);
      top_year = (cur.year  >= 8'h99);
      top_cent = (cur.century >= 8'h39);
      c_min  = top_sec;
      c_hour = c_min  & top_min;
      c_day  = c_hour & top_hour;
      c_mon  = c_day  & top_date;
      c_year = c_mon  & top_mon;
      c_cent = c_year & top_year;
   end

   rtc_bcd_field #(.WRAP_TO(8'h00)) u_sec  (.cur(cur.sec),     .carry_in(1'b1),   .at_top(top_sec),  .nxt(nxt.sec));
   rtc_bcd_field #(.WRAP_TO(8'h00)) u_min  (.cur(cur.min),     .carry_in(c_min),  .at_top(top_min),  .nxt(nxt.min));
   rtc_bcd_field #(.WRAP_TO(8'h00)) u_hour (.cur(cur.hour),    .carry_in(c_hour), .at_top(top_hour), .nxt(nxt.hour));
   rtc_bcd_field #(.WRAP_TO(8'h01)) u_day  (.cur(cur.day),     .carry_in(c_day),  .at_top(top_day),  .nxt(nxt.day));
   rtc_bcd_field #(.WRAP_TO(8'h01)) u_date (.cur(cur.date),    .carry_in(c_day),  .at_top(top_date), .nxt(nxt.date));
   rtc_bcd_field #(.WRAP_TO(8'h01)) u_mon  (.cur(cur.month),   .carry_in(c_mon),  .at_top(top_mon),  .nxt(nxt.month));
   rtc_bcd_field #(.WRAP_TO(8'h00)) u_year (.cur(cur.year),    .carry_in(c_year), .at_top(top_year), .nxt(nxt.year));
   rtc_bcd_field #(.WRAP_TO(8'h00)) u_cent (.cur(cur.century), .carry_in(c_cent), .at_top(top_cent), .nxt(nxt.century));

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int TICKS_PER_SEC = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_sub,
   input  logic run,
   input  logic restart,
   output logic sec_tick
);

   localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;

   logic [CW-1:0] cnt_q;
   logic          at_last;

   generate
      if ((TICKS_PER_SEC & (TICKS_PER_SEC - 1)) == 0) begin : g_pow2
         assign at_last = &cnt_q;
      end else begin : g_cmp
         localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
         assign at_last = (cnt_q == LAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt_q <= '0;
      else if (restart)          cnt_q <= '0;
      else if (tick_sub && run)  cnt_q <= at_last ? '0 : cnt_q + 1'b1;
   end

   assign sec_tick = tick_sub & run & ~restart & at_last;

endmodule

// File: rtl/rtc_guard.sv
module rtc_guard #(
   parameter int GUARD_TICKS = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_sub,
   input  logic hold,
   output logic guard_ok,
   output logic guard_expire
);

   localparam int CW = $clog2(GUARD_TICKS + 1);
   localparam logic [CW-1:0] G_FULL = CW'(GUARD_TICKS);
   localparam logic [CW-1:0] G_LAST = CW'(GUARD_TICKS - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                               cnt_q <= G_FULL;
      else if (hold)                            cnt_q <= '0;
      else if (tick_sub && (cnt_q != G_FULL))   cnt_q <= cnt_q + 1'b1;
   end

   assign guard_ok     = (cnt_q == G_FULL);
   assign guard_expire = tick_sub & ~hold & (cnt_q == G_LAST);

endmodule

// File: rtl/rtc_frozen_clock.sv
module rtc_frozen_clock
   import rtc_pkg::*;
#(
   parameter int TICKS_PER_SEC = 1024,
   parameter int GUARD_TICKS   = TICKS_PER_SEC / 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_sub,
   input  logic [3:0] bus_addr,
   input  logic       bus_we,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata
);

   initial begin
      assert (TICKS_PER_SEC >= 2) else $error("TICKS_PER_SEC must be at least 2");
      assert (GUARD_TICKS >= 1 && GUARD_TICKS <= TICKS_PER_SEC)
         else $error("GUARD_TICKS must lie in 1..TICKS_PER_SEC");
   end

   rtc_time_t int_q, ext_q, int_d, ext_d, calc, adv;
   logic      osc_q, hold_q;
   logic      sec_tick, guard_ok, guard_expire;
   logic      we_sec, we_ctrl, hold_rise, sync_now;

   assign we_sec  = bus_we && (bus_addr == OFF_SEC);
   assign we_ctrl = bus_we && (bus_addr == OFF_CTRL);

   rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick_sub(tick_sub),
      .run(~osc_q), .restart(we_sec), .sec_tick(sec_tick));

   rtc_guard #(.GUARD_TICKS(GUARD_TICKS)) u_guard (
      .clk(clk), .rst_n(rst_n), .tick_sub(tick_sub), .hold(hold_q),
      .guard_ok(guard_ok), .guard_expire(guard_expire));

   rtc_calendar u_cal (.cur(int_q), .nxt(calc));

   assign adv       = sec_tick ? calc : int_q;
   assign hold_rise = we_ctrl && bus_wdata[HOLD_BIT] && !hold_q;
   assign sync_now  = !hold_q && ((sec_tick && guard_ok) || guard_expire);

   always_comb begin
      int_d = adv;
      ext_d = ext_q;
      if (sync_now)  ext_d = adv;
      if (hold_rise) ext_d = int_q;
      if (bus_we) begin
         case (bus_addr)
            OFF_YEAR:  begin int_d.year    = bus_wdata & MSK_YEAR;  ext_d.year    = bus_wdata & MSK_YEAR;  end
            OFF_MONTH: begin int_d.month   = bus_wdata & MSK_MONTH; ext_d.month   = bus_wdata & MSK_MONTH; end
            OFF_DATE:  begin int_d.date    = bus_wdata & MSK_DATE;  ext_d.date    = bus_wdata & MSK_DATE;  end
            OFF_DAY:   begin int_d.day     = bus_wdata & MSK_DAY;   ext_d.day     = bus_wdata & MSK_DAY;   end
            OFF_HOUR:  begin int_d.hour    = bus_wdata & MSK_HOUR;  ext_d.hour    = bus_wdata & MSK_HOUR;  end
            OFF_MIN:   begin int_d.min     = bus_wdata & MSK_MIN;   ext_d.min     = bus_wdata & MSK_MIN;   end
            OFF_SEC:   begin int_d.sec     = bus_wdata & MSK_SEC;   ext_d.sec     = bus_wdata & MSK_SEC;   end
            OFF_CTRL:  begin int_d.century = bus_wdata & MSK_CENT;  ext_d.century = bus_wdata & MSK_CENT;  end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         int_q  <= TIME_AT_RESET;
         ext_q  <= TIME_AT_RESET;
         osc_q  <= 1'b1;
         hold_q <= 1'b0;
      end else begin
         int_q <= int_d;
         ext_q <= ext_d;
         if (we_sec)  osc_q  <= bus_wdata[STOP_BIT];
         if (we_ctrl) hold_q <= bus_wdata[HOLD_BIT];
      end
   end

   always_comb begin
      case (bus_addr)
         OFF_YEAR:  bus_rdata = ext_q.year;
         OFF_MONTH: bus_rdata = ext_q.month;
         OFF_DATE:  bus_rdata = ext_q.date;
         OFF_DAY:   bus_rdata = ext_q.day;
         OFF_HOUR:  bus_rdata = ext_q.hour;
         OFF_MIN:   bus_rdata = ext_q.min;
         OFF_SEC:   bus_rdata = {osc_q, 7'b0} | (ext_q.sec & MSK_SEC);
         OFF_CTRL:  bus_rdata = {1'b0, hold_q, 6'b0} | (ext_q.century & MSK_CENT);
         default:   bus_rdata = 8'h00;
      endcase
   end

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
   import rtc_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      bus_we,
   input logic      osc_q,
   input logic      hold_q,
   input logic      sec_tick,
   input logic      guard_ok,
   input logic      guard_expire,
   input rtc_time_t int_q,
   input rtc_time_t ext_q
);

   p_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_q && !bus_we) |=> $stable(int_q));

   p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && !bus_we) |=> $stable(ext_q));

   p_runs_in_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !osc_q && !bus_we) |=> (int_q != $past(int_q)));

   p_guard_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_q && !guard_ok && !guard_expire && !bus_we) |=> $stable(ext_q));

   p_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_q && guard_ok && sec_tick && !bus_we) |=> (ext_q == int_q));

   p_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_expire && !bus_we) |=> (guard_ok && ext_q == int_q));

endmodule

bind rtc_frozen_clock rtc_checker u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .osc_q(osc_q), .hold_q(hold_q),
   .sec_tick(sec_tick), .guard_ok(guard_ok), .guard_expire(guard_expire),
   .int_q(int_q), .ext_q(ext_q));

// File: tb/sim_rtc_frozen_clock.sv
module sim_rtc_frozen_clock;

   localparam int CLK_PERIOD = 10;
   localparam int TPS   = 8;
   localparam int GUARD = 4;
   localparam int NVEC  = 9;

   // {start, expected}; each half = {century, year, month, date, day, hour, min, sec}
   localparam logic [127:0] VEC [NVEC] = '{
      {64'h19_99_12_31_07_23_59_59, 64'h20_00_01_01_01_00_00_00},
      {64'h20_24_02_28_03_23_59_59, 64'h20_24_02_29_04_00_00_00},
      {64'h20_24_02_29_04_23_59_59, 64'h20_24_03_01_05_00_00_00},
      {64'h20_23_02_28_02_23_59_59, 64'h20_23_03_01_03_00_00_00},
      {64'h20_05_04_30_06_23_59_59, 64'h20_05_05_01_07_00_00_00},
      {64'h20_10_06_15_01_12_34_56, 64'h20_10_06_15_01_12_34_57},
      {64'h20_10_06_15_01_09_59_59, 64'h20_10_06_15_01_10_00_00},
      {64'h39_99_12_31_07_23_59_59, 64'h00_00_01_01_01_00_00_00},
      {64'h20_11_09_30_05_23_59_59, 64'h20_11_10_01_06_00_00_00}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_sub = 1'b0;
   logic [3:0] bus_addr = 4'h0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   rtc_frozen_clock #(.TICKS_PER_SEC(TPS), .GUARD_TICKS(GUARD)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_sub(tick_sub), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_sub = 1'b1;
         @(negedge clk); tick_sub = 1'b0;
      end
   endtask

   task automatic check(input string what, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: actual %h expected %h", what, got, exp);
      end
   endtask

   task automatic rd_check(input string what, input logic [3:0] a, input logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      check(what, {56'h0, d}, {56'h0, exp});
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0]  b [8];
      logic [63:0] st, ex;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      begin
         logic [7:0] rexp [16];
         for (int i = 0; i < 8; i++) rexp[i] = 8'h00;
         rexp[8] = 8'h00; rexp[9] = 8'h80; rexp[10] = 8'h00; rexp[11] = 8'h00;
         rexp[12] = 8'h01; rexp[13] = 8'h01; rexp[14] = 8'h01; rexp[15] = 8'h00;
         for (int i = 0; i < 16; i++) rd_check($sformatf("R1 offset %0d", i), 4'(i), rexp[i]);
      end
      tick(2 * TPS);
      rd_check("R3 stopped after reset", 4'h9, 8'h80);

      // vector walk: R2 R4 R5 R6
      for (int v = 0; v < NVEC; v++) begin
         st = VEC[v][127:64]; ex = VEC[v][63:0];
         wr(4'hF, st[55:48]); wr(4'hE, st[47:40]); wr(4'hD, st[39:32]);
         wr(4'hC, st[31:24]); wr(4'hB, st[23:16]); wr(4'hA, st[15:8]);
         wr(4'h8, st[63:56]); wr(4'h9, st[7:0]);
         tick(TPS);
         for (int k = 0; k < 8; k++) rd(4'(8 + k), b[k]);
         check($sformatf("R2 R4 R5 R6 vector %0d", v),
               {b[0] & 8'h3F, b[7], b[6], b[5], b[4], b[3], b[2], b[1]}, ex);
      end

      // R9 masks and ignored offsets
      wr(4'hA, 8'hFF); rd_check("R9 minutes mask", 4'hA, 8'h7F);
      wr(4'hC, 8'hFF); rd_check("R9 day mask", 4'hC, 8'h07);
      wr(4'hB, 8'hFF); rd_check("R9 hour mask", 4'hB, 8'h3F);
      wr(4'hE, 8'hFF); rd_check("R9 month mask", 4'hE, 8'h1F);
      wr(4'h3, 8'hAA); rd_check("R9 offset 3 ignores writes", 4'h3, 8'h00);
      wr(4'h8, 8'hFF); rd_check("R9 control bit 7 reads 0", 4'h8, 8'h7F);
      wr(4'h8, 8'h20); rd_check("R9 control century", 4'h8, 8'h20);

      // R7 R8 hold and guard
      wr(4'hF, 8'h30); wr(4'hE, 8'h03); wr(4'hD, 8'h05); wr(4'hC, 8'h02);
      wr(4'hB, 8'h10); wr(4'hA, 8'h00); wr(4'h9, 8'h00);
      tick(TPS);
      rd_check("R2 one second", 4'h9, 8'h01);
      wr(4'h8, 8'h60);
      tick(3 * TPS);
      rd_check("R7 seconds frozen in hold", 4'h9, 8'h01);
      rd_check("R7 minutes frozen in hold", 4'hA, 8'h00);
      wr(4'h8, 8'h20);
      tick(GUARD - 1);
      rd_check("R8 still frozen inside guard", 4'h9, 8'h01);
      tick(1);
      rd_check("R8 R7 resync at guard end shows running count", 4'h9, 8'h04);
      tick(TPS - GUARD);
      rd_check("R8 updates every second after guard", 4'h9, 8'h05);

      // R10 seconds write restarts prescaler and loads readout
      wr(4'h9, 8'h00);
      tick(5);
      wr(4'h9, 8'h20);
      rd_check("R10 write loads readout", 4'h9, 8'h20);
      tick(TPS - 1);
      rd_check("R10 no advance before full second", 4'h9, 8'h20);
      tick(1);
      rd_check("R10 advance after full second", 4'h9, 8'h21);
      wr(4'hA, 8'h42);
      rd_check("R10 minutes write loads readout", 4'hA, 8'h42);

      // R3 stop and restart
      wr(4'h9, 8'hC5);
      rd_check("R3 stop bit readback", 4'h9, 8'hC5);
      tick(3 * TPS);
      rd_check("R3 no advance while stopped", 4'h9, 8'hC5);
      wr(4'h9, 8'h45);
      tick(TPS);
      rd_check("R3 runs after clear", 4'h9, 8'h46);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule